// File: doc/BRIEF.md
# DMA Channel Request and Reload Controller

This block is the control core of one DMA channel. It keeps a request flag that a selectable trigger raises: one of several internal peripheral pulses, a software strobe in the control register, or a chosen edge on an external pin. The pin is first passed through a synchronizer. It also keeps an enable flag, an active address pointer and a transfer counter. Each time the channel is enabled, the pointer and the counter are restored from their reload values when the next transfer starts.

When the channel is enabled and a request is pending, the block sends a one-cycle start strobe to a bus master and clears the request. It then waits for the master's done pulse. Each completed unit advances the pointer by one and decrements the counter. When the counter reaches zero, the channel disables itself and pulses a terminal-count interrupt. Software programs the block through a small write port that has four registers.

Top module: `dmach_ctrl`

## Requirements
- R1: After synchronous reset, `chan_en`, `req_flag`, `xfer_start`, `tc_irq`, `active_ptr` and `xfer_count` are all 0.
- R2: Control register bits [11:8] select the trigger. Code k in 1..N_PERIPH selects `periph_req[k-1]`, code 0 selects the software strobe and code 15 selects the external pin. A selected peripheral pulse sets `req_flag` at the next clock edge whether or not the channel is enabled. Pulses on sources that are not selected leave it at 0.
- R3: A write to the control register (address 0) with bit 1 = 0 clears `req_flag`. A write with bit 1 = 1 leaves it unchanged.
- R4: A control write with bit 2 = 1 is a software strobe. With trigger code 0 it sets `req_flag` one cycle after the write edge. With any other code it does nothing.
- R5: With code 15, `ext_pin` passes through a two-flop synchronizer. Control bit 4 chooses the edge that sets `req_flag`: 0 means falling, 1 means rising. The flag rises at the third clock edge after the pin changes. The opposite edge has no effect.
- R6: When the channel is enabled, a request is pending and no transfer is outstanding, `xfer_start` pulses for one cycle and `req_flag` clears at the same edge. No further start is issued until `xfer_done` is seen.
- R7: A control write with bit 0 = 1 enables the channel and arms a reload. At the next start, `active_ptr` is loaded from the source register (address 1) when control bit 3 = 0, or from the destination register (address 2) when bit 3 = 1. `xfer_count` is loaded from the reload register (address 3).
- R8: Each `xfer_done` while a transfer is outstanding increments `active_ptr` by one and decrements `xfer_count` by one.
- R9: A done that takes `xfer_count` from 1 to 0 clears `chan_en` and pulses `tc_irq` for one cycle. A reload value of 0 therefore gives 2^CNT_W transfers.
- R10: Writing bit 0 = 1 again while the channel is active re-arms the reload. A done that completes while the reload is armed leaves the pointer and the counter unchanged, and the next start restarts from the reload values.
- R11: If a selected trigger occurs in the same cycle as a start clears the request, the request stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index: 0 control, 1 source, 2 destination, 3 count reload |
| wr_data | input | DATA_W | Write data |
| periph_req | input | N_PERIPH | Internal peripheral trigger pulses |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| xfer_done | input | 1 | Unit transfer completed by the bus master |
| xfer_start | output | 1 | One-cycle start strobe to the bus master |
| active_ptr | output | ADDR_W | Forward-direction address of the current unit |
| xfer_count | output | CNT_W | Remaining transfer count |
| chan_en | output | 1 | Channel enable flag |
| req_flag | output | 1 | Pending request flag |
| tc_irq | output | 1 | One-cycle terminal-count pulse |

## Verification
Two pairs of events can land on the same edge. The first pair is a start clearing the request while a new trigger sets it. The bench provokes this by holding a peripheral pulse for two cycles, so the second cycle coincides with the start. It then expects `xfer_start` and `req_flag` to be high together. The second pair is an enable rewrite and a transfer completion. The bench rewrites the enable bit while a transfer is outstanding, then sends the done. It judges the pair by the counter and pointer holding their values and by the next start showing the reload values.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_SRC    = 2'd1,
    REG_DST    = 2'd2,
    REG_RELOAD = 2'd3
  } reg_idx_e;

  // control register bit positions
  localparam int CB_EN     = 0;
  localparam int CB_KEEPRQ = 1;
  localparam int CB_SWTRIG = 2;
  localparam int CB_FWDDST = 3;
  localparam int CB_RISE   = 4;
  localparam int CB_SEL_LO = 8;

  typedef struct packed {
    logic             fwd_dst;
    logic             rise;
    logic [SEL_W-1:0] sel;
  } chan_cfg_t;
endpackage

// File: rtl/dmach_regfile.sv
module dmach_regfile
  import dmach_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output chan_cfg_t         cfg,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              en_set,
  output logic              en_clr,
  output logic              req_clr,
  output logic              sw_q
);
  logic wr_ctrl;
  assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);

  assign en_set  = wr_ctrl &&  wr_data[CB_EN];
  assign en_clr  = wr_ctrl && !wr_data[CB_EN];
  assign req_clr = wr_ctrl && !wr_data[CB_KEEPRQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      reload_q <= '0;
      sw_q     <= 1'b0;
    end else begin
      sw_q <= wr_ctrl && wr_data[CB_SWTRIG];
      if (wr_ctrl) begin
        cfg.fwd_dst <= wr_data[CB_FWDDST];
        cfg.rise    <= wr_data[CB_RISE];
        cfg.sel     <= wr_data[CB_SEL_LO +: SEL_W];
      end
      if (wr_en && wr_addr == REG_SRC)    src_q    <= wr_data[ADDR_W-1:0];
      if (wr_en && wr_addr == REG_DST)    dst_q    <= wr_data[ADDR_W-1:0];
      if (wr_en && wr_addr == REG_RELOAD) reload_q <= wr_data[CNT_W-1:0];
    end
  end

  // R4: a software strobe only follows a control write
  p_sw_from_write_r4: assert property (@(posedge clk) disable iff (rst)
    sw_q |-> $past(wr_en && wr_addr == REG_CTRL));
  // R2: selection changes only on a control write
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && wr_addr == REG_CTRL) |-> $stable(cfg.sel));
endmodule

// File: rtl/dmach_trigger.sv
module dmach_trigger
  import dmach_pkg::*;
#(
  parameter int N_PERIPH = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    sel,
  input  logic                rise,
  input  logic                sw_q,
  input  logic [N_PERIPH-1:0] periph_req,
  input  logic                ext_pin,
  output logic                trig_hit
);
  localparam int EXT_CODE = (1 << SEL_W) - 1;

  logic [1:0]          sync_q;
  logic                prev_q;
  logic                ext_rise, ext_fall, ext_edge;
  logic [N_PERIPH-1:0] src_match;
  logic                periph_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], ext_pin};
      prev_q <= sync_q[1];
    end
  end

  assign ext_rise = sync_q[1] && !prev_q;
  assign ext_fall = !sync_q[1] && prev_q;
  assign ext_edge = rise ? ext_rise : ext_fall;

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_src
    assign src_match[i] = (sel == SEL_W'(i + 1)) && periph_req[i];
  end
  assign periph_hit = |src_match;

  assign trig_hit = ((sel == '0) && sw_q)
                  || periph_hit
                  || ((sel == SEL_W'(EXT_CODE)) && ext_edge);

  // R5: one pin transition gives one detected edge of each kind
  p_rise_single_r5: assert property (@(posedge clk) disable iff (rst)
    ext_rise |=> !ext_rise);
  p_fall_single_r5: assert property (@(posedge clk) disable iff (rst)
    ext_fall |=> !ext_fall);
  // R2: at most one peripheral source can match the selection
  p_one_source_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_match));
endmodule

// File: rtl/dmach_engine.sv
module dmach_engine #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              req_clr,
  input  logic              trig_hit,
  input  logic              xfer_done,
  input  logic              fwd_dst,
  input  logic [ADDR_W-1:0] src_q,
  input  logic [ADDR_W-1:0] dst_q,
  input  logic [CNT_W-1:0]  reload_q,
  output logic              en_q,
  output logic              req_q,
  output logic              start_q,
  output logic              tc_q,
  output logic [ADDR_W-1:0] ptr_q,
  output logic [CNT_W-1:0]  cnt_q
);
  logic busy_q, pend_q;
  logic start_cond, done_ok, last_unit;

  assign start_cond = en_q && req_q && !busy_q;
  assign done_ok    = xfer_done && busy_q;
  assign last_unit  = done_ok && !pend_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      req_q   <= 1'b0;
      start_q <= 1'b0;
      tc_q    <= 1'b0;
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      ptr_q   <= '0;
      cnt_q   <= '0;
    end else begin
      start_q <= start_cond;
      tc_q    <= last_unit && !en_set;
      // a new trigger outranks both clearing paths
      req_q   <= trig_hit || (req_q && !start_cond && !req_clr);

      if (en_set)                    en_q <= 1'b1;
      else if (en_clr || last_unit)  en_q <= 1'b0;

      if (en_set)          pend_q <= 1'b1;
      else if (start_cond) pend_q <= 1'b0;

      if (start_cond)   busy_q <= 1'b1;
      else if (done_ok) busy_q <= 1'b0;

      if (start_cond && pend_q) begin
        ptr_q <= fwd_dst ? dst_q : src_q;
        cnt_q <= reload_q;
      end else if (done_ok && !pend_q) begin
        ptr_q <= ptr_q + 1'b1;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R6: start is a single-cycle strobe
  p_start_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
  // R6: request drops at the start unless re-triggered
  p_req_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (start_q && !$past(trig_hit)) |-> !req_q);
  // R11: simultaneous trigger keeps the request
  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (start_cond && trig_hit) |=> req_q);
  // R2: a trigger always leaves the request set
  p_trig_sets_r2: assert property (@(posedge clk) disable iff (rst)
    trig_hit |=> req_q);
  // R8: a completed unit counts down by one
  p_count_dec_r8: assert property (@(posedge clk) disable iff (rst)
    (done_ok && !pend_q) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));
  // R9: terminal pulse leaves the channel disabled at zero
  p_tc_state_r9: assert property (@(posedge clk) disable iff (rst)
    tc_q |-> (!en_q && cnt_q == '0));
  // R10: a done while a reload is armed changes nothing
  p_pend_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (done_ok && pend_q) |=> $stable(cnt_q) && $stable(ptr_q));
endmodule

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
  import dmach_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 16,
  parameter int N_PERIPH = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [N_PERIPH-1:0] periph_req,
  input  logic                ext_pin,
  input  logic                xfer_done,
  output logic                xfer_start,
  output logic [ADDR_W-1:0]   active_ptr,
  output logic [CNT_W-1:0]    xfer_count,
  output logic                chan_en,
  output logic                req_flag,
  output logic                tc_irq
);
  chan_cfg_t         cfg;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  reload_q;
  logic              en_set, en_clr, req_clr, sw_q, trig_hit;

  dmach_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg(cfg), .src_q(src_q), .dst_q(dst_q), .reload_q(reload_q),
    .en_set(en_set), .en_clr(en_clr), .req_clr(req_clr), .sw_q(sw_q)
  );

  dmach_trigger #(.N_PERIPH(N_PERIPH)) u_trig (
    .clk(clk), .rst(rst), .sel(cfg.sel), .rise(cfg.rise), .sw_q(sw_q),
    .periph_req(periph_req), .ext_pin(ext_pin), .trig_hit(trig_hit)
  );

  dmach_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst(rst), .en_set(en_set), .en_clr(en_clr), .req_clr(req_clr),
    .trig_hit(trig_hit), .xfer_done(xfer_done), .fwd_dst(cfg.fwd_dst),
    .src_q(src_q), .dst_q(dst_q), .reload_q(reload_q),
    .en_q(chan_en), .req_q(req_flag), .start_q(xfer_start), .tc_q(tc_irq),
    .ptr_q(active_ptr), .cnt_q(xfer_count)
  );
endmodule

// File: tb/sim_dmach_ctrl.sv
module sim_dmach_ctrl;
  localparam int NP = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [NP-1:0] periph_req = '0;
  logic          ext_pin = 1'b1;
  logic          xfer_done = 1'b0;
  logic          xfer_start, chan_en, req_flag, tc_irq;
  logic [15:0]   active_ptr, xfer_count;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dmach_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .periph_req(periph_req), .ext_pin(ext_pin), .xfer_done(xfer_done),
    .xfer_start(xfer_start), .active_ptr(active_ptr), .xfer_count(xfer_count),
    .chan_en(chan_en), .req_flag(req_flag), .tc_irq(tc_irq)
  );

  // {sel, peripheral pulse pattern, expected request}
  localparam logic [18:0] VEC [8] = '{
    {4'd1,  14'h0001, 1'b1},
    {4'd1,  14'h0002, 1'b0},
    {4'd5,  14'h0010, 1'b1},
    {4'd5,  14'h3FEF, 1'b0},
    {4'd14, 14'h2000, 1'b1},
    {4'd0,  14'h3FFF, 1'b0},
    {4'd15, 14'h3FFF, 1'b0},
    {4'd9,  14'h0100, 1'b1}
  };

  function automatic logic [15:0] ctrl(input logic en, keep, sw, fwd, rise,
                                       input logic [3:0] sel);
    return {4'h0, sel, 3'b000, rise, fwd, sw, keep, en};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [NP-1:0] v);
    @(negedge clk); periph_req = v;
    @(negedge clk); periph_req = '0;
  endtask

  task automatic done_pulse();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 en", chan_en, 0);
    chk("R1 req", req_flag, 0);
    chk("R1 start", xfer_start, 0);
    chk("R1 tc", tc_irq, 0);
    chk("R1 ptr", active_ptr, 0);
    chk("R1 cnt", xfer_count, 0);

    // R2: trigger routing table, channel disabled
    for (int k = 0; k < 8; k++) begin
      wr(2'd0, ctrl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, VEC[k][18:15]));
      pulse(VEC[k][14:1]);
      chk($sformatf("R2 vec%0d", k), req_flag, VEC[k][0]);
    end

    // R3: keep bit set preserves, clear bit clears
    wr(2'd0, ctrl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9));
    chk("R3 keep", req_flag, 1);
    wr(2'd0, ctrl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9));
    chk("R3 clear", req_flag, 0);

    // R4: software strobe
    wr(2'd0, ctrl(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0));
    chk("R4 before", req_flag, 0);
    @(negedge clk);
    chk("R4 set", req_flag, 1);
    wr(2'd0, ctrl(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1));
    @(negedge clk);
    chk("R4 other sel", req_flag, 0);

    // R5: external pin, falling edge
    wr(2'd0, ctrl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd15));
    ext_pin = 1'b0;
    @(negedge clk); chk("R5 lat1", req_flag, 0);
    @(negedge clk); chk("R5 lat2", req_flag, 0);
    @(negedge clk); chk("R5 fall", req_flag, 1);
    wr(2'd0, ctrl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd15));
    ext_pin = 1'b1;
    repeat (5) @(negedge clk);
    chk("R5 rise ignored", req_flag, 0);
    // rising edge selected
    wr(2'd0, ctrl(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd15));
    ext_pin = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 fall ignored", req_flag, 0);
    ext_pin = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 rise", req_flag, 1);

    // R6/R7/R8/R9: source-forward run of three units
    wr(2'd1, 16'h1000);
    wr(2'd2, 16'h2000);
    wr(2'd3, 16'd3);
    wr(2'd0, ctrl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1));
    chk("R7 en", chan_en, 1);
    chk("R6 idle", xfer_start, 0);
    pulse(14'h0001);
    chk("R2 enabled", req_flag, 1);
    @(negedge clk);
    chk("R6 start", xfer_start, 1);
    chk("R6 req clr", req_flag, 0);
    chk("R7 ptr src", active_ptr, 16'h1000);
    chk("R7 cnt", xfer_count, 3);
    @(negedge clk);
    chk("R6 pulse", xfer_start, 0);
    pulse(14'h0001);
    @(negedge clk);
    chk("R6 busy nostart", xfer_start, 0);
    chk("R6 busy req", req_flag, 1);
    done_pulse();
    chk("R8 cnt", xfer_count, 2);
    chk("R8 ptr", active_ptr, 16'h1001);
    @(negedge clk);
    chk("R6 restart", xfer_start, 1);
    done_pulse();
    chk("R8 cnt2", xfer_count, 1);
    chk("R8 ptr2", active_ptr, 16'h1002);
    pulse(14'h0001);
    @(negedge clk);
    chk("R6 third", xfer_start, 1);
    done_pulse();
    chk("R9 cnt0", xfer_count, 0);
    chk("R9 en", chan_en, 0);
    chk("R9 tc", tc_irq, 1);
    @(negedge clk);
    chk("R9 tc pulse", tc_irq, 0);

    // R11 + R7 destination-forward
    wr(2'd3, 16'd2);
    wr(2'd0, ctrl(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1));
    @(negedge clk); periph_req = 14'h0001;
    @(negedge clk);
    @(negedge clk); periph_req = '0;
    chk("R11 start", xfer_start, 1);
    chk("R11 req kept", req_flag, 1);
    chk("R7 ptr dst", active_ptr, 16'h2000);
    chk("R7 cnt dst", xfer_count, 2);
    done_pulse();
    chk("R8 dst cnt", xfer_count, 1);
    @(negedge clk);
    chk("R11 next start", xfer_start, 1);

    // R10: enable rewrite while a unit is outstanding
    wr(2'd0, ctrl(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1));
    done_pulse();
    chk("R10 cnt hold", xfer_count, 1);
    chk("R10 ptr hold", active_ptr, 16'h2001);
    chk("R10 no tc", tc_irq, 0);
    chk("R10 en", chan_en, 1);
    pulse(14'h0001);
    @(negedge clk);
    chk("R10 start", xfer_start, 1);
    chk("R10 ptr reload", active_ptr, 16'h2000);
    chk("R10 cnt reload", xfer_count, 2);

    report();
    $finish;
  end
endmodule